// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank State Tracker

This block sits on the device side of a DDR2 memory model. It runs on one single-rate system clock that stands in for the differential pair. On every rising edge it samples chip select, the row strobe, the column strobe, write enable, the bank address and the address bus, and turns them into one decoded command. It keeps an open/idle flag for each of eight banks. It also follows the power state set by clock enable, which can be awake, precharge power-down, active power-down or self refresh.

The decoded command, the illegal flag and the mode-register write fields are registered. They appear one clock after the edge that sampled the inputs, in the same cycle that the bank flags take their new values. Commands are carried out only while the device is awake and clock enable is high. The first edge with clock enable high after power-down only wakes the device. Self-refresh exit is reported on the power output as soon as clock enable rises, without waiting for an edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When cs_n_i is high at a sampling edge, the command is ignored: cmd_o shows code 0 (no-op) and no bank flag changes.
- R2: With the code {cs_n_i, ras_n_i, cas_n_i, we_n_i}, 0111 decodes to no-op (cmd_o 0), 0011 to activate (1), 0101 to read (2), 0100 to write (3), 0010 to precharge (4 or 5), 0001 to refresh (6) and 0000 to mode register set (7). The result appears on cmd_o one clock after the sampling edge.
- R3: An activate sent to an idle bank sets bank_open_o[bank_i]. Bit n of bank_open_o belongs to bank n.
- R4: A precharge with addr_i[10] low closes only bank bank_i and reports code 4. With addr_i[10] high it closes every bank and reports code 5. Precharging an idle bank is legal.
- R5: A read or write with addr_i[10] high is accepted and then marks its bank idle.
- R6: A read or write to an idle bank, or an activate to an open bank, raises illegal_o for one cycle and changes no bank flag. cmd_o still shows the command.
- R7: The reserved code 0110 raises illegal_o, shows code 0 on cmd_o and changes no bank flag.
- R8: A mode register set pulses mr_wr_o high for one cycle. mr_sel_o takes bank_i, which selects the base or an extended mode register, and mr_op_o takes addr_i as the opcode.
- R9: cke_i low at an edge while awake enters power-down. pwr_o becomes 1 (precharge power-down) if all banks are idle, or 2 (active power-down) if any bank is open. A command sampled with cke_i low, or while not awake, is not carried out and shows code 0.
- R10: cke_i low together with a refresh code while all banks are idle enters self refresh: pwr_o becomes 3 and cmd_o shows 8. With any bank open, the same input enters active power-down instead.
- R11: Power-down exit is taken at the first edge with cke_i high. Self-refresh exit shows pwr_o 0 as soon as cke_i is high, before any edge. The command sampled at an exit edge is not carried out.
- R12: Asynchronous active-low reset clears all bank flags, sets cmd_o to 0, pwr_o to 0 (awake), and clears illegal_o and mr_wr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| bank_i | input | 3 | Bank address |
| addr_i | input | 16 | Row/column address, bit 10 is the precharge-all and auto-precharge bit |
| cmd_o | output | 4 | Decoded command code |
| bank_open_o | output | 8 | Open flag per bank |
| illegal_o | output | 1 | Illegal command seen in the previous cycle |
| mr_wr_o | output | 1 | Mode register write pulse |
| mr_sel_o | output | 3 | Selected mode register |
| mr_op_o | output | 16 | Mode register opcode |
| pwr_o | output | 2 | Power state: 0 awake, 1 precharge power-down, 2 active power-down, 3 self refresh |

## Verification
The decoder is driven with a table of command codes that first opens, then reuses, then closes banks in different orders. Reading and writing idle banks, reactivating open ones and sending the reserved code separate legal from illegal handling. Auto-precharge and single-bank precharge are compared with precharge-all to show whether address bit 10 widens the close to every bank or only adds a close after the access. Power entry is tried with banks open and with banks idle, and with and without a refresh code, to separate the three low-power states. Exits are probed between clock edges so that the immediate self-refresh exit can be told apart from the clocked power-down exit.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_PRE  = 4'd4,
    CMD_PREA = 4'd5,
    CMD_REF  = 4'd6,
    CMD_MRS  = 4'd7,
    CMD_SREF = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_AWAKE    = 2'd0,
    PWR_PRE_PD   = 2'd1,
    PWR_ACT_PD   = 2'd2,
    PWR_SELF_REF = 2'd3
  } pwr_e;

  // Code bits ordered {cs_n, ras_n, cas_n, we_n}
  function automatic cmd_e decode_cmd(input logic [3:0] code, input logic a10);
    cmd_e c;
    case (code)
      4'b0011: c = CMD_ACT;
      4'b0101: c = CMD_RD;
      4'b0100: c = CMD_WR;
      4'b0010: c = a10 ? CMD_PREA : CMD_PRE;
      4'b0001: c = CMD_REF;
      4'b0000: c = CMD_MRS;
      default: c = CMD_NOP;
    endcase
    return c;
  endfunction

  function automatic logic is_reserved(input logic [3:0] code);
    return code == 4'b0110;
  endfunction

  // Next open flag of one bank
  function automatic logic bank_next(input logic cur, input logic hit,
                                     input cmd_e cmd, input logic ap);
    logic n;
    n = cur;
    if (cmd == CMD_PREA) begin
      n = 1'b0;
    end else if (hit) begin
      case (cmd)
        CMD_ACT: n = 1'b1;
        CMD_PRE: n = 1'b0;
        CMD_RD, CMD_WR: if (cur && ap) n = 1'b0;
        default: n = cur;
      endcase
    end
    return n;
  endfunction

  // State taken when clock enable drops while awake
  function automatic pwr_e low_power_target(input logic any_open, input logic ref_req);
    pwr_e p;
    if (any_open)     p = PWR_ACT_PD;
    else if (ref_req) p = PWR_SELF_REF;
    else              p = PWR_PRE_PD;
    return p;
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic [3:0] code_i,
  input  logic       a10_i,
  input  logic       exec_i,
  output cmd_e       raw_cmd_o,
  output cmd_e       cmd_o,
  output logic       reserved_o
);
  assign raw_cmd_o  = decode_cmd(code_i, a10_i);
  assign cmd_o      = exec_i ? raw_cmd_o : CMD_NOP;
  assign reserved_o = exec_i & is_reserved(code_i);
endmodule

// File: rtl/sdcmd_bank_table.sv
module sdcmd_bank_table
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_e                 cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 ap_i,
  output logic [NUM_BANKS-1:0] open_o,
  output logic                 any_open_o,
  output logic                 illegal_o
);
  logic [NUM_BANKS-1:0] open_q;
  logic [NUM_BANKS-1:0] open_d;
  logic                 sel_open;

  assign sel_open = open_q[bank_i];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit       = (bank_i == BANK_W'(b));
    assign open_d[b] = bank_next(open_q[b], hit && !illegal_o, cmd_i, ap_i);
  end

  assign illegal_o = ((cmd_i == CMD_ACT) && sel_open) ||
                     (((cmd_i == CMD_RD) || (cmd_i == CMD_WR)) && !sel_open);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= '0;
    else        open_q <= open_d;
  end

  assign open_o     = open_q;
  assign any_open_o = |open_q;
endmodule

// File: rtl/sdcmd_power.sv
module sdcmd_power
  import sdcmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke_i,
  input  logic any_open_i,
  input  logic ref_req_i,
  output pwr_e state_o,
  output pwr_e pwr_o,
  output logic exec_o,
  output logic sref_entry_o
);
  pwr_e state_q;
  pwr_e state_d;
  logic entry;

  assign exec_o       = (state_q == PWR_AWAKE) && cke_i;
  assign entry        = (state_q == PWR_AWAKE) && !cke_i;
  assign sref_entry_o = entry && ref_req_i && !any_open_i;

  always_comb begin
    state_d = state_q;
    if (state_q == PWR_AWAKE) begin
      if (!cke_i) state_d = low_power_target(any_open_i, ref_req_i);
    end else if (cke_i) begin
      state_d = PWR_AWAKE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PWR_AWAKE;
    else        state_q <= state_d;
  end

  // Self-refresh exit does not wait for an edge
  assign pwr_o   = ((state_q == PWR_SELF_REF) && cke_i) ? PWR_AWAKE : state_q;
  assign state_o = state_q;
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 16,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke_i,
  input  logic                 cs_n_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [3:0]           cmd_o,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 illegal_o,
  output logic                 mr_wr_o,
  output logic [BANK_W-1:0]    mr_sel_o,
  output logic [ADDR_W-1:0]    mr_op_o,
  output logic [1:0]           pwr_o
);
  logic [3:0] code_w;
  cmd_e       raw_cmd_w;
  cmd_e       exec_cmd_w;
  logic       reserved_w;
  logic       exec_w;
  logic       sref_entry_w;
  logic       any_open_w;
  logic       bank_illegal_w;
  logic       ref_req_w;
  pwr_e       pwr_state_w;
  pwr_e       pwr_vis_w;

  cmd_e                cmd_q;
  logic                illegal_q;
  logic                mr_wr_q;
  logic [BANK_W-1:0]   mr_sel_q;
  logic [ADDR_W-1:0]   mr_op_q;

  assign code_w    = {cs_n_i, ras_n_i, cas_n_i, we_n_i};
  assign ref_req_w = (raw_cmd_w == CMD_REF);

  sdcmd_decode u_dec (
    .code_i    (code_w),
    .a10_i     (addr_i[AP_BIT]),
    .exec_i    (exec_w),
    .raw_cmd_o (raw_cmd_w),
    .cmd_o     (exec_cmd_w),
    .reserved_o(reserved_w)
  );

  sdcmd_bank_table #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (exec_cmd_w),
    .bank_i    (bank_i),
    .ap_i      (addr_i[AP_BIT]),
    .open_o    (bank_open_o),
    .any_open_o(any_open_w),
    .illegal_o (bank_illegal_w)
  );

  sdcmd_power u_pwr (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke_i       (cke_i),
    .any_open_i  (any_open_w),
    .ref_req_i   (ref_req_w),
    .state_o     (pwr_state_w),
    .pwr_o       (pwr_vis_w),
    .exec_o      (exec_w),
    .sref_entry_o(sref_entry_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= CMD_NOP;
      illegal_q <= 1'b0;
      mr_wr_q   <= 1'b0;
      mr_sel_q  <= '0;
      mr_op_q   <= '0;
    end else begin
      cmd_q     <= sref_entry_w ? CMD_SREF : exec_cmd_w;
      illegal_q <= bank_illegal_w || reserved_w;
      mr_wr_q   <= (exec_cmd_w == CMD_MRS);
      if (exec_cmd_w == CMD_MRS) begin
        mr_sel_q <= bank_i;
        mr_op_q  <= addr_i;
      end
    end
  end

  assign cmd_o     = cmd_q;
  assign illegal_o = illegal_q;
  assign mr_wr_o   = mr_wr_q;
  assign mr_sel_o  = mr_sel_q;
  assign mr_op_o   = mr_op_q;
  assign pwr_o     = pwr_vis_w;
endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n_i,
  input logic                 ras_n_i,
  input logic                 cas_n_i,
  input logic                 we_n_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic                 ap_i,
  input logic                 exec_w,
  input logic [3:0]           cmd_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic                 illegal_o,
  input logic                 mr_wr_o,
  input logic [1:0]           pwr_state
);
  AST_DESELECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (cmd_o == 4'd0) && $stable(bank_open_o)); // R1

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_w && !cs_n_i && !ras_n_i && cas_n_i && we_n_i) |=> bank_open_o[$past(bank_i)]); // R3

  AST_PREA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_w && !cs_n_i && !ras_n_i && cas_n_i && !we_n_i && ap_i) |=> (bank_open_o == '0)); // R4

  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (bank_open_o == $past(bank_open_o))); // R6

  AST_MR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mr_wr_o |-> (cmd_o == 4'd7)); // R8

  AST_ACT_PD_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 2'd2) && ($past(pwr_state) == 2'd0)) |-> ($past(bank_open_o) != '0)); // R9
endmodule

bind sdram_cmd_tracker sdcmd_checker #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n_i     (cs_n_i),
  .ras_n_i    (ras_n_i),
  .cas_n_i    (cas_n_i),
  .we_n_i     (we_n_i),
  .bank_i     (bank_i),
  .ap_i       (addr_i[AP_BIT]),
  .exec_w     (exec_w),
  .cmd_o      (cmd_o),
  .bank_open_o(bank_open_o),
  .illegal_o  (illegal_o),
  .mr_wr_o    (mr_wr_o),
  .pwr_state  (pwr_state_w)
);

// File: tb/sdram_cmd_tracker_test.sv
module sdram_cmd_tracker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke_i = 1'b1;
  logic        cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [2:0]  bank_i = '0;
  logic [15:0] addr_i = '0;
  logic [3:0]  cmd_o;
  logic [7:0]  bank_open_o;
  logic        illegal_o, mr_wr_o;
  logic [2:0]  mr_sel_o;
  logic [15:0] mr_op_o;
  logic [1:0]  pwr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sdram_cmd_tracker uut (
    .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .bank_i(bank_i), .addr_i(addr_i),
    .cmd_o(cmd_o), .bank_open_o(bank_open_o), .illegal_o(illegal_o),
    .mr_wr_o(mr_wr_o), .mr_sel_o(mr_sel_o), .mr_op_o(mr_op_o), .pwr_o(pwr_o)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [3:0]  code;
    logic [2:0]  bank;
    logic [15:0] addr;
    logic [3:0]  cmd;
    logic [7:0]  opn;
    logic        ill;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{"R2", 4'b0111, 3'd0, 16'h0000, 4'd0, 8'h00, 1'b0},
    '{"R3", 4'b0011, 3'd2, 16'h0000, 4'd1, 8'h04, 1'b0},
    '{"R6", 4'b0011, 3'd2, 16'h0000, 4'd1, 8'h04, 1'b1},
    '{"R6", 4'b0101, 3'd5, 16'h0000, 4'd2, 8'h04, 1'b1},
    '{"R3", 4'b0011, 3'd5, 16'h0000, 4'd1, 8'h24, 1'b0},
    '{"R2", 4'b0100, 3'd5, 16'h0000, 4'd3, 8'h24, 1'b0},
    '{"R5", 4'b0101, 3'd2, 16'h0400, 4'd2, 8'h20, 1'b0},
    '{"R1", 4'b1011, 3'd0, 16'h0000, 4'd0, 8'h20, 1'b0},
    '{"R4", 4'b0010, 3'd3, 16'h0000, 4'd4, 8'h20, 1'b0},
    '{"R3", 4'b0011, 3'd7, 16'h0000, 4'd1, 8'hA0, 1'b0},
    '{"R4", 4'b0010, 3'd5, 16'h0000, 4'd4, 8'h80, 1'b0},
    '{"R7", 4'b0110, 3'd7, 16'h0000, 4'd0, 8'h80, 1'b1},
    '{"R3", 4'b0011, 3'd0, 16'h0000, 4'd1, 8'h81, 1'b0},
    '{"R5", 4'b0100, 3'd0, 16'h0400, 4'd3, 8'h80, 1'b0},
    '{"R4", 4'b0010, 3'd1, 16'h0400, 4'd5, 8'h00, 1'b0},
    '{"R2", 4'b0001, 3'd0, 16'h0000, 4'd6, 8'h00, 1'b0},
    '{"R1", 4'b1001, 3'd0, 16'h0000, 4'd0, 8'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic cke, input logic [3:0] code, input logic [2:0] bank,
                       input logic [15:0] addr);
    cke_i = cke;
    {cs_n_i, ras_n_i, cas_n_i, we_n_i} = code;
    bank_i = bank;
    addr_i = addr;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 cmd", 32'(cmd_o), 0);
    chk("R12 open", 32'(bank_open_o), 0);
    chk("R12 pwr", 32'(pwr_o), 0);
    chk("R12 illegal", 32'(illegal_o), 0);
    chk("R12 mr_wr", 32'(mr_wr_o), 0);
    rst_n = 1'b1;
    drive(1'b1, 4'b0111, 3'd0, 16'h0);
    cycle();

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].code, VECS[i].bank, VECS[i].addr);
      cycle();
      chk($sformatf("%s cmd v%0d", VECS[i].tag, i), 32'(cmd_o), 32'(VECS[i].cmd));
      chk($sformatf("%s open v%0d", VECS[i].tag, i), 32'(bank_open_o), 32'(VECS[i].opn));
      chk($sformatf("%s illegal v%0d", VECS[i].tag, i), 32'(illegal_o), 32'(VECS[i].ill));
      chk($sformatf("%s pwr v%0d", VECS[i].tag, i), 32'(pwr_o), 0);
    end

    // R8 mode register set
    drive(1'b1, 4'b0000, 3'd2, 16'h1234);
    cycle();
    chk("R8 cmd", 32'(cmd_o), 7);
    chk("R8 pulse", 32'(mr_wr_o), 1);
    chk("R8 sel", 32'(mr_sel_o), 2);
    chk("R8 op", 32'(mr_op_o), 32'h1234);
    drive(1'b1, 4'b0111, 3'd0, 16'h0);
    cycle();
    chk("R8 pulse end", 32'(mr_wr_o), 0);

    // R9 active power-down
    drive(1'b1, 4'b0011, 3'd1, 16'h0);
    cycle();
    chk("R3 open b1", 32'(bank_open_o), 32'h02);
    drive(1'b0, 4'b0111, 3'd0, 16'h0);
    cycle();
    chk("R9 act pd", 32'(pwr_o), 2);
    drive(1'b0, 4'b0011, 3'd3, 16'h0);
    cycle();
    chk("R9 ignored cmd", 32'(cmd_o), 0);
    chk("R9 ignored open", 32'(bank_open_o), 32'h02);
    // R11 exit edge does not execute
    drive(1'b1, 4'b0011, 3'd3, 16'h0);
    #1 chk("R11 pd exit waits", 32'(pwr_o), 2);
    cycle();
    chk("R11 pd exit", 32'(pwr_o), 0);
    chk("R11 exit cmd", 32'(cmd_o), 0);
    chk("R11 exit open", 32'(bank_open_o), 32'h02);

    // R9 precharge power-down
    drive(1'b1, 4'b0010, 3'd0, 16'h0400);
    cycle();
    chk("R4 prea", 32'(bank_open_o), 0);
    drive(1'b0, 4'b0111, 3'd0, 16'h0);
    cycle();
    chk("R9 pre pd", 32'(pwr_o), 1);
    drive(1'b1, 4'b0111, 3'd0, 16'h0);
    #1 chk("R11 pre pd waits", 32'(pwr_o), 1);
    cycle();
    chk("R11 pre pd exit", 32'(pwr_o), 0);

    // R10 self refresh
    drive(1'b0, 4'b0001, 3'd0, 16'h0);
    cycle();
    chk("R10 sref pwr", 32'(pwr_o), 3);
    chk("R10 sref cmd", 32'(cmd_o), 8);
    drive(1'b0, 4'b0111, 3'd0, 16'h0);
    cycle();
    chk("R10 sref hold", 32'(pwr_o), 3);
    drive(1'b1, 4'b0111, 3'd0, 16'h0);
    #1 chk("R11 sref async exit", 32'(pwr_o), 0);
    cycle();
    chk("R11 sref exit reg", 32'(pwr_o), 0);

    // R10 refresh with open bank gives active power-down
    drive(1'b1, 4'b0011, 3'd4, 16'h0);
    cycle();
    drive(1'b0, 4'b0001, 3'd0, 16'h0);
    cycle();
    chk("R10 open blocks sref", 32'(pwr_o), 2);
    chk("R10 open blocks cmd", 32'(cmd_o), 0);
    drive(1'b1, 4'b0111, 3'd0, 16'h0);
    cycle();

    // R12 asynchronous reset mid-run
    chk("R12 pre-reset open", 32'(bank_open_o), 32'h10);
    rst_n = 1'b0;
    #1 chk("R12 async open", 32'(bank_open_o), 0);
    chk("R12 async pwr", 32'(pwr_o), 0);
    cycle();
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule